// File: doc/BRIEF.md
# Windowed 64-bit Register Access Bridge

This bridge lets a host that only has a 32-bit register port reach a bank of 64-bit registers inside a peripheral. The host sees a small window of 32-bit registers: an upper data half, a lower data half, a command word, an error-clear word and a status word. Writing the command word starts one 64-bit transfer on the device side. A write transfer sends the two data halves joined together. A read transfer loads the returned 64-bit value back into the two halves, where the host can then read it.

The host port is a plain valid/ready register slave. Read data is combinational from the addressed register. The device port is a valid/ready master that carries a 64-bit payload and takes back a response error bit. Every 32-bit word on the host wire is big-endian. The bridge byte-swaps each host word into its internal value, and swaps each internal value back on the way out. While a device transfer is in flight, the bridge stalls host accesses. The exception is a command write: the bridge accepts it at once, drops it and flags it as an error.

Top module: `ibr_bridge`

## Requirements
- R1: After reset, dev_valid_o is low, host_ready_o is high, and both data halves and the status word read as zero.
- R2: Every host word is big-endian. For an internal value V, the host wire carries {V[7:0],V[15:8],V[23:16],V[31:24]} on both host_wdata_i and host_rdata_o.
- R3: Take a command word C, accepted at offset 0x08 while idle, whose bits 30..DEV_AW are all zero. With C[31] set, the next cycle raises dev_valid_o with dev_write_o high, dev_addr_o = C[DEV_AW-1:0] and dev_wdata_o = {upper half, lower half}.
- R4: Such a command with C[31] clear starts a read. When the read completes without error, the upper half (offset 0x00) becomes dev_rdata_i[63:32] and the lower half (offset 0x04) becomes dev_rdata_i[31:0].
- R5: Once raised, dev_valid_o and its address, direction and payload hold steady until a cycle with dev_ready_i high. That cycle ends the transfer, and each accepted command starts at most one transfer.
- R6: While a transfer is in flight, host_ready_o is low for every access except a write to the command offset.
- R7: A command write accepted while a transfer is in flight sets the error flag and starts nothing.
- R8: A command whose bits 30..DEV_AW are not all zero does not decode. It sets the error flag and starts nothing.
- R9: A transfer that completes with dev_err_i high sets the error flag and leaves both data halves unchanged.
- R10: The status word (offset 0x1C) has the error flag in bit 31 and zero in all other bits. Any write to offset 0x18 clears the flag.
- R11: The command offset, the interrupt offset 0x20 and all unmapped offsets read as zero. Writes to 0x20 and to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_valid_i | input | 1 | Host access request |
| host_write_i | input | 1 | Host access is a write |
| host_addr_i | input | HOST_AW | Byte offset in the window |
| host_wdata_i | input | 32 | Host write word (big-endian) |
| host_ready_o | output | 1 | Access accepted this cycle |
| host_rdata_o | output | 32 | Addressed register (big-endian) |
| dev_valid_o | output | 1 | Device transfer request |
| dev_write_o | output | 1 | Device transfer is a write |
| dev_addr_o | output | DEV_AW | Target register address |
| dev_wdata_o | output | 64 | Device write value |
| dev_ready_i | input | 1 | Device completes transfer |
| dev_rdata_i | input | 64 | Device read value |
| dev_err_i | input | 1 | Device response error |

## Verification
The assertions check the cycle-level rules on every cycle. These are the device request holding steady while it waits, the host stall while a transfer is in flight, the launch after a good command, and each way the error flag gets set or cleared. Other behaviour can only be shown by the bench's scenarios, compared each clock against a behavioural model. That covers the byte order on the host wire, the round trip of a read value into the two halves, the halves staying unchanged after an error response, and unmapped offsets reading zero.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int OFF_HI   = 'h00;
  localparam int OFF_LO   = 'h04;
  localparam int OFF_CMD  = 'h08;
  localparam int OFF_CLR  = 'h18;
  localparam int OFF_STAT = 'h1C;
  localparam int OFF_IRQ  = 'h20;
  localparam int CMD_WR_BIT = 31;

  typedef enum logic {DEV_IDLE, DEV_BUSY} dev_st_e;

  function automatic logic [31:0] bswap32(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/ibr_dev_master.sv
module ibr_dev_master #(
  parameter int DEV_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              launch_wr_i,
  input  logic [DEV_AW-1:0] launch_addr_i,
  input  logic [63:0]       launch_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_err_o,
  output logic              done_rd_o,
  output logic [63:0]       done_data_o,
  output logic              dev_valid_o,
  output logic              dev_write_o,
  output logic [DEV_AW-1:0] dev_addr_o,
  output logic [63:0]       dev_wdata_o,
  input  logic              dev_ready_i,
  input  logic [63:0]       dev_rdata_i,
  input  logic              dev_err_i
);
  import ibr_pkg::*;

  dev_st_e           st_q;
  logic              wr_q;
  logic [DEV_AW-1:0] addr_q;
  logic [63:0]       data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= DEV_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (st_q == DEV_IDLE) begin
      if (launch_i) begin
        st_q   <= DEV_BUSY;
        wr_q   <= launch_wr_i;
        addr_q <= launch_addr_i;
        data_q <= launch_data_i;
      end
    end else if (dev_ready_i) begin
      st_q <= DEV_IDLE;
    end
  end

  assign busy_o      = (st_q == DEV_BUSY);
  assign dev_valid_o = busy_o;
  assign dev_write_o = wr_q;
  assign dev_addr_o  = addr_q;
  assign dev_wdata_o = data_q;
  assign done_o      = busy_o && dev_ready_i;
  assign done_err_o  = dev_err_i;
  assign done_rd_o   = !wr_q;
  assign done_data_o = dev_rdata_i;
endmodule

// File: rtl/ibr_host_window.sv
module ibr_host_window #(
  parameter int HOST_AW = 6,
  parameter int DEV_AW  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_valid_i,
  input  logic               host_write_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [31:0]        host_wdata_i,
  output logic               host_ready_o,
  output logic [31:0]        host_rdata_o,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic               done_err_i,
  input  logic               done_rd_i,
  input  logic [63:0]        done_data_i,
  output logic               launch_o,
  output logic               launch_wr_o,
  output logic [DEV_AW-1:0]  launch_addr_o,
  output logic [63:0]        launch_data_o,
  output logic               err_o
);
  import ibr_pkg::*;

  logic [31:0] hi_q, lo_q;
  logic        err_q;
  logic [31:0] wval;
  logic        acc, sel_hi, sel_lo, sel_cmd, sel_clr, sel_stat;
  logic        cmd_wr, addr_bad, busy_hit;

  assign wval     = bswap32(host_wdata_i);
  assign sel_hi   = host_addr_i == HOST_AW'(OFF_HI);
  assign sel_lo   = host_addr_i == HOST_AW'(OFF_LO);
  assign sel_cmd  = host_addr_i == HOST_AW'(OFF_CMD);
  assign sel_clr  = host_addr_i == HOST_AW'(OFF_CLR);
  assign sel_stat = host_addr_i == HOST_AW'(OFF_STAT);

  // command writes pass during a transfer so they can be flagged
  assign host_ready_o = !busy_i || (host_write_i && sel_cmd);
  assign acc          = host_valid_i && host_ready_o;
  assign cmd_wr       = acc && host_write_i && sel_cmd;
  assign addr_bad     = |wval[30:DEV_AW];
  assign busy_hit     = cmd_wr && busy_i;

  assign launch_o      = cmd_wr && !busy_i && !addr_bad;
  assign launch_wr_o   = wval[CMD_WR_BIT];
  assign launch_addr_o = wval[DEV_AW-1:0];
  assign launch_data_o = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (done_i && !done_err_i && done_rd_i) begin
        hi_q <= done_data_i[63:32];
        lo_q <= done_data_i[31:0];
      end else if (acc && host_write_i && sel_hi) begin
        hi_q <= wval;
      end else if (acc && host_write_i && sel_lo) begin
        lo_q <= wval;
      end
      if (busy_hit || (cmd_wr && addr_bad) || (done_i && done_err_i))
        err_q <= 1'b1;
      else if (acc && host_write_i && sel_clr)
        err_q <= 1'b0;
    end
  end

  always_comb begin
    logic [31:0] v;
    v = '0;
    if (sel_hi)        v = hi_q;
    else if (sel_lo)   v = lo_q;
    else if (sel_stat) v = {err_q, 31'b0};
    host_rdata_o = bswap32(v);
  end

  assign err_o = err_q;
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge #(
  parameter int HOST_AW = 6,
  parameter int DEV_AW  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_valid_i,
  input  logic               host_write_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [31:0]        host_wdata_i,
  output logic               host_ready_o,
  output logic [31:0]        host_rdata_o,
  output logic               dev_valid_o,
  output logic               dev_write_o,
  output logic [DEV_AW-1:0]  dev_addr_o,
  output logic [63:0]        dev_wdata_o,
  input  logic               dev_ready_i,
  input  logic [63:0]        dev_rdata_i,
  input  logic               dev_err_i
);
  logic              busy_w, done_w, done_err_w, done_rd_w, err_w;
  logic [63:0]       done_data_w, launch_data_w;
  logic              launch_w, launch_wr_w;
  logic [DEV_AW-1:0] launch_addr_w;

  ibr_host_window #(.HOST_AW(HOST_AW), .DEV_AW(DEV_AW)) u_win (
    .clk_i, .rst_ni,
    .host_valid_i, .host_write_i, .host_addr_i, .host_wdata_i,
    .host_ready_o, .host_rdata_o,
    .busy_i(busy_w), .done_i(done_w), .done_err_i(done_err_w),
    .done_rd_i(done_rd_w), .done_data_i(done_data_w),
    .launch_o(launch_w), .launch_wr_o(launch_wr_w),
    .launch_addr_o(launch_addr_w), .launch_data_o(launch_data_w),
    .err_o(err_w)
  );

  ibr_dev_master #(.DEV_AW(DEV_AW)) u_dev (
    .clk_i, .rst_ni,
    .launch_i(launch_w), .launch_wr_i(launch_wr_w),
    .launch_addr_i(launch_addr_w), .launch_data_i(launch_data_w),
    .busy_o(busy_w), .done_o(done_w), .done_err_o(done_err_w),
    .done_rd_o(done_rd_w), .done_data_o(done_data_w),
    .dev_valid_o, .dev_write_o, .dev_addr_o, .dev_wdata_o,
    .dev_ready_i, .dev_rdata_i, .dev_err_i
  );
endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk #(
  parameter int HOST_AW = 6,
  parameter int DEV_AW  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               host_valid_i,
  input logic               host_write_i,
  input logic [HOST_AW-1:0] host_addr_i,
  input logic [31:0]        host_wdata_i,
  input logic               host_ready_o,
  input logic               dev_valid_o,
  input logic               dev_write_o,
  input logic [DEV_AW-1:0]  dev_addr_o,
  input logic [63:0]        dev_wdata_o,
  input logic               dev_ready_i,
  input logic               dev_err_i,
  input logic               err_i
);
  import ibr_pkg::*;

  logic [31:0] cmd_w;
  logic        cmd_acc, clr_acc, cmd_bad;
  assign cmd_w   = bswap32(host_wdata_i);
  assign cmd_acc = host_valid_i && host_write_i && host_addr_i == HOST_AW'(OFF_CMD);
  assign clr_acc = host_valid_i && host_ready_o && host_write_i && host_addr_i == HOST_AW'(OFF_CLR);
  assign cmd_bad = |cmd_w[30:DEV_AW];

  AST_LAUNCH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_valid_o && cmd_acc && !cmd_bad |=>
      dev_valid_o && dev_addr_o == $past(cmd_w[DEV_AW-1:0]) && dev_write_o == $past(cmd_w[31])); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_o && !dev_ready_i |=>
      dev_valid_o && $stable(dev_addr_o) && $stable(dev_wdata_o) && $stable(dev_write_o)); // R5
  AST_HOST_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_o && !(host_write_i && host_addr_i == HOST_AW'(OFF_CMD)) |-> !host_ready_o); // R6
  AST_BUSY_CMD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_o && cmd_acc |=> err_i); // R7
  AST_BAD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_valid_o && cmd_acc && cmd_bad |=> err_i && !dev_valid_o); // R8
  AST_RESP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_o && dev_ready_i && dev_err_i |=> err_i); // R9
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_acc && !dev_valid_o |=> !err_i); // R10
endmodule

bind ibr_bridge ibr_bridge_chk #(.HOST_AW(HOST_AW), .DEV_AW(DEV_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .host_valid_i(host_valid_i), .host_write_i(host_write_i),
  .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
  .host_ready_o(host_ready_o),
  .dev_valid_o(dev_valid_o), .dev_write_o(dev_write_o),
  .dev_addr_o(dev_addr_o), .dev_wdata_o(dev_wdata_o),
  .dev_ready_i(dev_ready_i), .dev_err_i(dev_err_i),
  .err_i(err_w)
);

// File: tb/tb_ibr_bridge.sv
module tb_ibr_bridge;
  localparam int HAW = 6;
  localparam int DAW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           hv = 0, hw = 0;
  logic [HAW-1:0] ha = '0;
  logic [31:0]    hd = '0;
  logic           host_ready_o;
  logic [31:0]    host_rdata_o;
  logic           dev_valid_o, dev_write_o;
  logic [DAW-1:0] dev_addr_o;
  logic [63:0]    dev_wdata_o;
  logic           dev_ready = 0, dev_err = 0;
  logic [63:0]    dev_rdata = '0;

  ibr_bridge #(.HOST_AW(HAW), .DEV_AW(DAW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_valid_i(hv), .host_write_i(hw), .host_addr_i(ha), .host_wdata_i(hd),
    .host_ready_o(host_ready_o), .host_rdata_o(host_rdata_o),
    .dev_valid_o(dev_valid_o), .dev_write_o(dev_write_o),
    .dev_addr_o(dev_addr_o), .dev_wdata_o(dev_wdata_o),
    .dev_ready_i(dev_ready), .dev_rdata_i(dev_rdata), .dev_err_i(dev_err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [31:0] sw(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0]    m_hi, m_lo;
  logic           m_err, m_busy, m_wr;
  logic [DAW-1:0] m_addr;
  logic [63:0]    m_wd;

  function automatic bit m_ready();
    return !m_busy || (hw && ha == 6'h08);
  endfunction

  function automatic logic [31:0] m_rd();
    case (ha)
      6'h00: return sw(m_hi);
      6'h04: return sw(m_lo);
      6'h1C: return sw({m_err, 31'b0});
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_err = 0; m_busy = 0; m_wr = 0; m_addr = 0; m_wd = 0;
    end else begin
      bit acc, ob;
      logic [31:0] v;
      acc = hv && m_ready();
      ob  = m_busy;
      v   = sw(hd);
      if (ob && dev_ready) begin
        m_busy = 0;
        if (dev_err) m_err = 1;
        else if (!m_wr) begin m_hi = dev_rdata[63:32]; m_lo = dev_rdata[31:0]; end
      end
      if (acc && hw) begin
        case (ha)
          6'h00: m_hi = v;
          6'h04: m_lo = v;
          6'h08: begin
            if (ob) m_err = 1;
            else if (v[30:DAW] != 0) m_err = 1;
            else begin m_busy = 1; m_wr = v[31]; m_addr = v[DAW-1:0]; m_wd = {m_hi, m_lo}; end
          end
          6'h18: m_err = 0;
          default: ;
        endcase
      end
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(dev_valid_o == m_busy, "R5 dev_valid", 64'(dev_valid_o), 64'(m_busy));
      chk(host_ready_o == m_ready(), "R6 host_ready", 64'(host_ready_o), 64'(m_ready()));
      chk(host_rdata_o == m_rd(), (ha == 6'h1C) ? "R10 status" : "R2 R4 R11 rdata",
          64'(host_rdata_o), 64'(m_rd()));
      if (m_busy) begin
        chk(dev_addr_o == m_addr && dev_write_o == m_wr, "R3 dev addr/dir",
            64'({dev_write_o, dev_addr_o}), 64'({m_wr, m_addr}));
        if (m_wr) chk(dev_wdata_o == m_wd, "R3 dev wdata", dev_wdata_o, m_wd);
      end
    end
  end

  // device responder
  int dev_lat = 0, dev_cnt = 0;
  always @(posedge clk) begin
    #1;
    if (dev_valid_o) begin
      dev_ready = (dev_cnt >= dev_lat);
      dev_cnt++;
    end else begin
      dev_ready = 0;
      dev_cnt = 0;
    end
  end

  task automatic host_acc(input bit wr, input logic [HAW-1:0] a, input logic [31:0] val,
                          output logic [31:0] rd);
    bit r;
    @(posedge clk); #1;
    hv = 1; hw = wr; ha = a; hd = sw(val);
    forever begin
      @(negedge clk);
      r = host_ready_o;
      rd = sw(host_rdata_o);
      @(posedge clk);
      if (r) break;
    end
    #1 hv = 0; hw = 0;
  endtask

  task automatic wr32(input logic [HAW-1:0] a, input logic [31:0] val);
    logic [31:0] d;
    host_acc(1, a, val, d);
  endtask

  task automatic rd32(input logic [HAW-1:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    host_acc(0, a, 0, d);
    chk(d == exp, tag, 64'(d), 64'(exp));
  endtask

  task automatic wait_idle();
    while (dev_valid_o) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(dev_valid_o == 0 && host_ready_o == 1, "R1 reset outputs",
        64'({dev_valid_o, host_ready_o}), 64'b01);
    rd32(6'h1C, 0, "R1 status");
    rd32(6'h00, 0, "R1 upper");
    rd32(6'h04, 0, "R1 lower");

    // R2: byte order of host words
    wr32(6'h00, 32'hDEADBEEF);
    wr32(6'h04, 32'h01234567);
    rd32(6'h00, 32'hDEADBEEF, "R2 upper round trip");
    @(posedge clk); #1 ha = 6'h04; @(negedge clk);
    chk(host_rdata_o == 32'h67452301, "R2 wire order", 64'(host_rdata_o), 64'h67452301);

    // R3 write with latency, R6 stall seen by the model
    dev_lat = 3;
    wr32(6'h08, 32'h8000_0012);
    @(negedge clk);
    chk(dev_wdata_o == 64'hDEADBEEF_01234567 && dev_write_o, "R3 write payload",
        dev_wdata_o, 64'hDEADBEEF_01234567);
    rd32(6'h1C, 0, "R6 stalled status read");
    wait_idle();

    // R7 command during a transfer
    dev_lat = 4;
    wr32(6'h08, 32'h8000_0020);
    wr32(6'h08, 32'h0000_0021);
    wait_idle();
    rd32(6'h1C, 32'h8000_0000, "R7 error flag");
    wr32(6'h18, 0);
    rd32(6'h1C, 0, "R10 clear");

    // R4 read
    dev_lat = 2;
    dev_rdata = 64'hA1B2C3D4_E5F60718;
    wr32(6'h08, 32'h0000_0033);
    wait_idle();
    rd32(6'h00, 32'hA1B2C3D4, "R4 upper");
    rd32(6'h04, 32'hE5F60718, "R4 lower");

    // R8 bad address
    wr32(6'h08, 32'h0010_0005);
    @(negedge clk);
    chk(dev_valid_o == 0, "R8 no launch", 64'(dev_valid_o), 0);
    rd32(6'h1C, 32'h8000_0000, "R8 error flag");
    wr32(6'h18, 0);

    // R9 error response leaves halves
    dev_lat = 1;
    dev_err = 1;
    dev_rdata = 64'h11111111_22222222;
    wr32(6'h08, 32'h0000_0044);
    wait_idle();
    dev_err = 0;
    rd32(6'h1C, 32'h8000_0000, "R9 error flag");
    rd32(6'h00, 32'hA1B2C3D4, "R9 upper kept");
    rd32(6'h04, 32'hE5F60718, "R9 lower kept");
    wr32(6'h18, 0);

    // R11 zero reads, ignored writes
    wr32(6'h20, 32'hFFFF_FFFF);
    wr32(6'h0C, 32'h1234_5678);
    rd32(6'h20, 0, "R11 irq reads zero");
    rd32(6'h0C, 0, "R11 unmapped");
    rd32(6'h08, 0, "R11 command");
    rd32(6'h00, 32'hA1B2C3D4, "R11 halves untouched");
    rd32(6'h1C, 0, "R11 no error");

    // zero-latency write, R5
    dev_lat = 0;
    wr32(6'h04, 32'h0BADF00D);
    wr32(6'h08, 32'h8000_00FF);
    wait_idle();
    rd32(6'h1C, 0, "R5 clean completion");

    repeat (3) @(posedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule